// File: doc/BRIEF.md
# Rank Boundary Address Decoder

This block sits at the front of a memory controller. It takes a physical request address and works out which memory channel and which rank of that channel serve it. Software describes the populated memory with eight programmable boundary bytes, four for each of two channels. Each byte holds a running total of installed memory in 32 MB units, counted from the lowest rank up to and including that rank. The decoder compares the request address against these totals at 128 MB granularity.

A mode bit selects how the two channels share the address space. In stacked mode, the two channels are laid end to end, so channel B's totals carry on from channel A's last rank. In interleaved mode, a low address bit alternates between the two channels. Each boundary unit then covers twice as much address, because the two channels together hold every rank.

A request is presented with a valid strobe. The channel, the rank and an out-of-range flag come back one clock later, together with a result strobe.

Top module: `rank_boundary_decoder`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low after a cycle with `req_valid` low.
- R2: A boundary byte's limit is its bits 6:2 in 128 MB steps, compared against address bits 31:27. An address is below a rank's limit when those address bits are strictly less than the limit. Bits 1:0 of a boundary byte have no effect on decoding.
- R3: In stacked mode (mode bit 0), the boundary order is `cfg_idx` 0–3 for channel A ranks 0–3, then 4–7 for channel B ranks 0–3. The result is the first rank in that order whose limit lies above the address. `rsp_chan` is 0 for channel A and 1 for channel B, and `rsp_rank` is the rank number within the channel.
- R4: A rank whose boundary equals the previous boundary in the order never receives an address. This covers a single-sided module, an empty channel A (all bytes 00h) and an empty channel B (all bytes equal to channel A rank 3).
- R5: Bit 7 set in a boundary byte makes that rank's limit 4 GB, so every address below it is in range.
- R6: An address at or above every limit gives `rsp_oor` = 1 with `rsp_chan` = 0 and `rsp_rank` = 0.
- R7: In interleaved mode (mode bit 1), `rsp_chan` equals address bit 6. The rank is the first rank of that channel whose limit is strictly greater than address bits 31:28, which doubles each unit's span. Out of range applies when no rank of that channel qualifies.
- R8: Writing `cfg_data` at `cfg_idx` with `cfg_we` high, or the mode with `mode_we` high, affects requests from the next cycle on. A request in the same cycle as the write uses the old value.
- R9: Reset sets every boundary byte to 00h, selects stacked mode and clears `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Boundary byte write strobe |
| cfg_idx | input | 3 | Boundary byte select (0–3 channel A, 4–7 channel B) |
| cfg_data | input | 8 | Boundary byte value |
| mode_we | input | 1 | Mode write strobe |
| mode_wdata | input | 1 | Mode value: 0 stacked, 1 interleaved |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request physical address |
| rsp_valid | output | 1 | Result strobe, one cycle after request |
| rsp_chan | output | 1 | Decoded channel |
| rsp_rank | output | 2 | Decoded rank within channel |
| rsp_oor | output | 1 | Address beyond populated memory |

## Verification
The hardest case to reach is an address that lands exactly on a boundary shared by an empty rank, or by an empty channel that repeats the previous total. There the decoder must move past several equal limits to the next populated rank, or fall out of range. The bench programs layouts with such repeated totals, including a wholly empty channel A, an empty channel B, a single-sided module and a 4 GB top bit. For each layout it sweeps every 128 MB step, at both the first and last byte of the step, in both modes and on both values of address bit 6. The expected result is computed from byte-level address arithmetic.

// File: rtl/rbd_pkg.sv
// Package rbd_pkg
// Shared widths, types and the boundary-to-limit conversion for the rank
// boundary decoder. Assumes 8-bit boundary bytes whose two low bits are
// don't-care and whose top bit stands for the full 4 GB.
package rbd_pkg;
    localparam int BND_W = 8;
    localparam int LIM_W = BND_W - 2;   // bits 7:2 of a boundary byte

    typedef logic [BND_W-1:0] bnd_t;
    typedef logic [LIM_W-1:0] lim_t;

    // Limit in 128 MB steps; bit 7 lands on the 4 GB weight.
    function automatic lim_t bnd_to_limit(input bnd_t b);
        return {b[BND_W-1], b[BND_W-2:2]};
    endfunction
endpackage

// File: rtl/rbd_regfile.sv
// Module rbd_regfile
// Holds the cumulative rank boundary bytes for both channels and the
// channel mode bit. Writes land at the clock edge, so a request issued in
// the same cycle still sees the previous contents. Reset clears all
// boundaries to zero and selects stacked mode.
module rbd_regfile
    import rbd_pkg::*;
#(
    parameter int TOTAL = 8,
    localparam int IDX_W = $clog2(TOTAL)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_idx,
    input  logic [BND_W-1:0]      cfg_data,
    input  logic                  mode_we,
    input  logic                  mode_wdata,
    output logic [TOTAL-1:0][BND_W-1:0] bnd_q,
    output logic                  mode_ilv
);

    // Boundary byte storage with single-byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bnd_q <= '0;
        end else if (cfg_we) begin
            bnd_q[cfg_idx] <= cfg_data;
        end
    end

    // Channel mode bit: 0 stacked, 1 interleaved.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_ilv <= 1'b0;
        end else if (mode_we) begin
            mode_ilv <= mode_wdata;
        end
    end

    // R9: reset leaves zero boundaries and stacked mode behind.
    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (bnd_q == '0 && mode_ilv == 1'b0));

    // R8: a written byte is visible the following cycle.
    a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> bnd_q[$past(cfg_idx)] == $past(cfg_data));

endmodule

// File: rtl/rbd_rank_search.sv
// Module rbd_rank_search
// Compares a key against an ordered list of cumulative limits and returns
// the first entry whose limit is strictly above the key. Equal neighbouring
// limits (empty ranks) can never be picked. Purely combinational; the clock
// and reset only serve the local assertions.
module rbd_rank_search
    import rbd_pkg::*;
#(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0][LIM_W-1:0] lims,
    input  logic [LIM_W-1:0]      key,
    output logic                  hit,
    output logic [IDX_W-1:0]      idx
);

    logic [N-1:0] above;

    // One comparator per rank.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign above[g] = lims[g] > key;
    end

    // Priority pick of the lowest-ordered rank whose limit lies above.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (above[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    // R3: the chosen rank's limit lies above the key.
    a_r3_hit_above: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> lims[idx] > key);

    // R4: the rank before the chosen one does not lie above the key.
    a_r4_first_match: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && idx != '0) |-> lims[idx - 1'b1] <= key);

endmodule

// File: rtl/rank_boundary_decoder.sv
// Module rank_boundary_decoder
// Maps a physical request address to channel, rank and an out-of-range
// flag using cumulative boundary bytes. Stacked mode searches all ranks of
// both channels in order; interleaved mode takes the channel from one
// address bit and searches that channel with a doubled unit span.
// Assumes software keeps boundaries non-decreasing and, in interleaved
// mode, equal rank-3 bytes in both channels. Result is one cycle later.
module rank_boundary_decoder
    import rbd_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int RANKS   = 4,
    parameter int ILV_BIT = 6,
    localparam int TOTAL  = 2 * RANKS,
    localparam int IDX_W  = $clog2(TOTAL),
    localparam int RANK_W = $clog2(RANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [BND_W-1:0]  cfg_data,
    input  logic              mode_we,
    input  logic              mode_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_chan,
    output logic [RANK_W-1:0] rsp_rank,
    output logic              rsp_oor
);

    localparam int UNIT_LSB = ADDR_W - (LIM_W - 1);   // 128 MB step bit

    logic [TOTAL-1:0][BND_W-1:0] bnd_q;
    logic                        mode_ilv;
    logic [TOTAL-1:0][LIM_W-1:0] lim_all;
    logic [RANKS-1:0][LIM_W-1:0] lim_ch;
    logic [LIM_W-1:0]            key_stk;
    logic [LIM_W-1:0]            key_ilv;
    logic                        stk_hit;
    logic [IDX_W-1:0]            stk_idx;
    logic                        ilv_hit;
    logic [RANK_W-1:0]           ilv_idx;
    logic                        hit_n;
    logic                        chan_n;
    logic [RANK_W-1:0]           rank_n;

    rbd_regfile #(.TOTAL(TOTAL)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_data   (cfg_data),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .bnd_q      (bnd_q),
        .mode_ilv   (mode_ilv)
    );

    // Convert each boundary byte to its limit.
    for (genvar g = 0; g < TOTAL; g++) begin : g_lim
        assign lim_all[g] = bnd_to_limit(bnd_q[g]);
    end

    // Interleaved mode searches only the channel chosen by the address bit.
    for (genvar r = 0; r < RANKS; r++) begin : g_chsel
        assign lim_ch[r] = req_addr[ILV_BIT] ? lim_all[RANKS + r] : lim_all[r];
    end

    // Stacked key: 128 MB step; interleaved key: 256 MB step.
    assign key_stk = {1'b0, req_addr[ADDR_W-1:UNIT_LSB]};
    assign key_ilv = {2'b00, req_addr[ADDR_W-1:UNIT_LSB+1]};

    rbd_rank_search #(.N(TOTAL)) u_stk (
        .clk   (clk),
        .rst_n (rst_n),
        .lims  (lim_all),
        .key   (key_stk),
        .hit   (stk_hit),
        .idx   (stk_idx)
    );

    rbd_rank_search #(.N(RANKS)) u_ilv (
        .clk   (clk),
        .rst_n (rst_n),
        .lims  (lim_ch),
        .key   (key_ilv),
        .hit   (ilv_hit),
        .idx   (ilv_idx)
    );

    // Select the result for the active mode and blank it when out of range.
    always_comb begin
        if (mode_ilv) begin
            hit_n  = ilv_hit;
            chan_n = req_addr[ILV_BIT];
            rank_n = ilv_idx;
        end else begin
            hit_n  = stk_hit;
            chan_n = stk_idx[IDX_W-1];
            rank_n = stk_idx[RANK_W-1:0];
        end
        if (!hit_n) begin
            chan_n = 1'b0;
            rank_n = '0;
        end
    end

    // Result strobe follows the request strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
        end
    end

    // Result fields are captured only for a valid request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_chan <= 1'b0;
            rsp_rank <= '0;
            rsp_oor  <= 1'b0;
        end else if (req_valid) begin
            rsp_chan <= chan_n;
            rsp_rank <= rank_n;
            rsp_oor  <= !hit_n;
        end
    end

    // R1: result strobe tracks the request strobe one cycle later.
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R6: an out-of-range result carries zero channel and rank.
    a_r6_oor_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_oor) |-> (rsp_chan == 1'b0 && rsp_rank == '0));

    // R5: a 4 GB top bit on the last stacked boundary keeps every address in range.
    a_r5_full_top: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mode_ilv && bnd_q[TOTAL-1][BND_W-1]) |=> !rsp_oor);

    // R7: an interleaved hit reports the channel of the steering address bit.
    a_r7_chan_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_ilv && ilv_hit) |=> rsp_chan == $past(req_addr[ILV_BIT]));

endmodule

// File: tb/sim_rank_boundary_decoder.sv
module sim_rank_boundary_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [7:0]  cfg_data = '0;
    logic        mode_we = 1'b0;
    logic        mode_wdata = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_chan;
    logic [1:0]  rsp_rank;
    logic        rsp_oor;

    int checks = 0;
    int errors = 0;
    logic [7:0] mirror [8];
    logic       mirror_ilv = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    rank_boundary_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_chan(rsp_chan), .rsp_rank(rsp_rank), .rsp_oor(rsp_oor)
    );

    function automatic longint unsigned top_bytes(input logic [7:0] b);
        if (b[7]) return 64'h1_0000_0000;
        return longint'(b[6:2]) * 64'h800_0000;
    endfunction

    // Independent reference: byte-level address arithmetic.
    task automatic model(input logic [31:0] a, output logic e_oor,
                         output logic e_ch, output logic [1:0] e_rk);
        longint unsigned av;
        e_oor = 1'b1; e_ch = 1'b0; e_rk = 2'd0;
        if (!mirror_ilv) begin
            av = longint'(a);
            for (int i = 7; i >= 0; i--)
                if (av < top_bytes(mirror[i])) begin
                    e_oor = 1'b0; e_ch = (i >= 4); e_rk = 2'(i % 4);
                end
        end else begin
            av = (longint'(a[31:7]) << 6) | longint'(a[5:0]);
            for (int r = 3; r >= 0; r--)
                if (av < top_bytes(mirror[(a[6] ? 4 : 0) + r])) begin
                    e_oor = 1'b0; e_ch = a[6]; e_rk = 2'(r);
                end
        end
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
        mirror[idx] = d;
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        mode_we = 1'b1; mode_wdata = m;
        @(negedge clk);
        mode_we = 1'b0;
        mirror_ilv = m;
    endtask

    task automatic load(input logic [7:0] a0, a1, a2, a3, b0, b1, b2, b3);
        wr(0, a0); wr(1, a1); wr(2, a2); wr(3, a3);
        wr(4, b0); wr(5, b1); wr(6, b2); wr(7, b3);
    endtask

    // One request, result sampled one negedge later.
    task automatic probe(input logic [31:0] a, input string req);
        logic e_oor, e_ch;
        logic [1:0] e_rk;
        model(a, e_oor, e_ch, e_rk);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid === 1'b1 && rsp_oor === e_oor && rsp_chan === e_ch &&
            rsp_rank === e_rk, req, $sformatf("addr %h {valid,oor,chan,rank}", a),
            {28'd0, rsp_valid, rsp_oor, rsp_chan, rsp_rank[1]} << 1 | rsp_rank[0],
            {28'd0, 1'b1, e_oor, e_ch, e_rk[1]} << 1 | e_rk[0]);
    endtask

    task automatic sweep_stacked(input string req);
        for (int k = 0; k < 32; k++) begin
            probe(32'(k) << 27, req);
            probe((32'(k) << 27) | 32'h07FF_FFFF, req);
        end
    endtask

    task automatic sweep_ilv(input string req);
        for (int k = 0; k < 16; k++)
            for (int b = 0; b < 2; b++) begin
                probe((32'(k) << 28) | (32'(b) << 6), req);
                probe((32'(k) << 28) | 32'h0FFF_FFBF | (32'(b) << 6), req);
            end
    endtask

    initial begin : watchdog
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        for (int i = 0; i < 8; i++) mirror[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state, no result strobe, all boundaries zero.
        chk(rsp_valid === 1'b0, "R9", "rsp_valid after reset", 32'(rsp_valid), 0);
        probe(32'h0000_0000, "R9");
        probe(32'hFFFF_FFFF, "R6");

        // R8: write and request in the same cycle use the old byte.
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'd0; cfg_data = 8'h10;
        req_valid = 1'b1; req_addr = 32'h0800_0000;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        chk(rsp_oor === 1'b1, "R8", "same-cycle write unseen", 32'(rsp_oor), 1);
        mirror[0] = 8'h10;
        probe(32'h0800_0000, "R8");

        // R1: no request, no result strobe.
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R1", "idle rsp_valid", 32'(rsp_valid), 0);

        // R2 R3 R4: stacked, single-sided A1, empty B0, low bits set in B1.
        load(8'h04, 8'h08, 8'h08, 8'h10, 8'h10, 8'h1B, 8'h20, 8'h20);
        sweep_stacked("R3");

        // R4: empty channel A.
        load(8'h00, 8'h00, 8'h00, 8'h00, 8'h08, 8'h10, 8'h10, 8'h14);
        sweep_stacked("R4");

        // R4: empty channel B repeats channel A rank 3.
        load(8'h08, 8'h0C, 8'h14, 8'h18, 8'h18, 8'h18, 8'h18, 8'h18);
        sweep_stacked("R4");

        // R5: full 4 GB on the last boundary.
        load(8'h04, 8'h08, 8'h0C, 8'h10, 8'h10, 8'h40, 8'h60, 8'h80);
        sweep_stacked("R5");
        probe(32'hFFFF_FFFF, "R5");

        // R7 R8: interleaved, lower ranks differ, rank 3 equal.
        load(8'h04, 8'h08, 8'h0C, 8'h10, 8'h04, 8'h04, 8'h0C, 8'h10);
        set_mode(1'b1);
        sweep_ilv("R7");
        probe(32'h0400_0040, "R7");

        // R8: back to stacked mode takes effect at once.
        set_mode(1'b0);
        probe(32'h1000_0040, "R8");
        probe(32'h2000_0000, "R6");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule